// File: doc/BRIEF.md
# Loadable Clearable Binary Counter

This block is an up counter of parameterised width. It is built so that single slices can be joined into a longer counter. On each rising clock edge, each bit of the count register takes its next value from a two-way selector. The selector passes either the parallel load data or the counted value. Its output is then ANDed with an active-low synchronous clear. Clear therefore wins over load, and load wins over counting.

The counted value advances by the carry-in, and only while the count enable is high. A carry network runs beside the per-bit next-value logic. It is computed separately from that logic and produces a combinational carry-out. The carry-out goes high when every bit is one and the carry-in is high. A wider counter is made by feeding one slice's carry-out into the next slice's carry-in, with clear, load and enable shared between the slices.

The counter has no down direction and no asynchronous reset. A synchronous clear or load sets its initial state. A parameter picks the carry network: a bit-serial ripple, or a per-bit prefix AND that is shallower.

Top module: `lcc_counter`

## Requirements
- R1: When clear_n is 0 at a rising clock edge, count becomes all zeros on that edge, whatever load, count_en and carry_in are.
- R2: When clear_n is 0 and load is 1 together, the clear wins and count becomes zero, not load_data.
- R3: When clear_n is 1 and load is 1 at a rising edge, count takes load_data on that edge, whatever count_en and carry_in are.
- R4: When clear_n is 1, load is 0, count_en is 1 and carry_in is 1, count increases by one on the edge.
- R5: When clear_n is 1, load is 0, count_en is 1 and carry_in is 0, count keeps its value.
- R6: When clear_n is 1, load is 0 and count_en is 0, count keeps its value, whatever carry_in is.
- R7: carry_out is 1 exactly when carry_in is 1 and every bit of count is 1. It is combinational and does not depend on count_en.
- R8: Incrementing from all ones gives all zeros (wrap).
- R9: Two slices joined by carry_out to carry_in, sharing clear_n, load and count_en, with the low slice's carry_in held at 1, count as one counter of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low synchronous clear, overrides load |
| load | input | 1 | Synchronous parallel load |
| load_data | input | WIDTH | Value taken on load |
| count_en | input | 1 | Allows counting |
| carry_in | input | 1 | Increment amount (0 or 1) from the lower slice |
| count | output | WIDTH | Registered count value |
| carry_out | output | 1 | All ones and carry_in, to the next slice |

## Verification
The main instance is built with WIDTH=4 and the ripple carry network. At this width the wrap from 15 to 0 and the carry-out corner are reached many times during the random run. A second pair of slices is built with WIDTH=3 and the prefix carry network. The pair is chained into a 6-bit counter, so the other generate variant and the cascade through carry_out are both covered. Directed steps force clear together with load, a load of all ones followed by a wrap, and carry_in toggling while the count is all ones.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

   typedef enum logic [0:0] {
      LCC_CARRY_RIPPLE = 1'b0,
      LCC_CARRY_PREFIX = 1'b1
   } lcc_carry_e;

   // next counted bit: toggles when a carry reaches it and counting is enabled
   function automatic logic lcc_count_bit(input logic q, input logic c, input logic en);
      return q ^ (c & en);
   endfunction

   // carry passed to the stage above
   function automatic logic lcc_carry_bit(input logic q, input logic c);
      return q & c;
   endfunction

endpackage

// File: rtl/lcc_carry_net.sv
module lcc_carry_net
   import lcc_pkg::*;
#(
   parameter int         WIDTH      = 8,
   parameter lcc_carry_e CARRY_MODE = LCC_CARRY_RIPPLE
) (
   input  logic [WIDTH-1:0] cnt,
   input  logic             cin,
   output logic [WIDTH:0]   carry
);

   assign carry[0] = cin;

   generate
      if (CARRY_MODE == LCC_CARRY_RIPPLE) begin : g_ripple
         for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            assign carry[i+1] = lcc_carry_bit(cnt[i], carry[i]);
         end
      end else begin : g_prefix
         for (genvar i = 1; i <= WIDTH; i++) begin : g_stage
            assign carry[i] = cin & (&cnt[i-1:0]);
         end
      end
   endgenerate

endmodule

// File: rtl/lcc_bit_cell.sv
module lcc_bit_cell
   import lcc_pkg::*;
(
   input  logic q,
   input  logic c,
   input  logic en,
   input  logic ld,
   input  logic ld_bit,
   input  logic clr_n,
   output logic d
);

   logic counted;
   logic selected;

   always_comb begin
      counted  = lcc_count_bit(q, c, en);
      selected = ld ? ld_bit : counted;
      d        = selected & clr_n;
   end

endmodule

// File: rtl/lcc_counter.sv
module lcc_counter
   import lcc_pkg::*;
#(
   parameter int         WIDTH      = 8,
   parameter lcc_carry_e CARRY_MODE = LCC_CARRY_RIPPLE
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_data,
   input  logic             count_en,
   input  logic             carry_in,
   output logic [WIDTH-1:0] count,
   output logic             carry_out
);

   localparam int CARRY_W = WIDTH + 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("lcc_counter: WIDTH must be at least 1");
      end
   endgenerate

   logic [CARRY_W-1:0] carry;
   logic [WIDTH-1:0]   next_q;
   logic [WIDTH-1:0]   q;

   lcc_carry_net #(
      .WIDTH      (WIDTH),
      .CARRY_MODE (CARRY_MODE)
   ) u_carry (
      .cnt   (q),
      .cin   (carry_in),
      .carry (carry)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         lcc_bit_cell u_cell (
            .q      (q[i]),
            .c      (carry[i]),
            .en     (count_en),
            .ld     (load),
            .ld_bit (load_data[i]),
            .clr_n  (clear_n),
            .d      (next_q[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      q <= next_q;
   end

   assign count     = q;
   assign carry_out = carry[WIDTH];

endmodule

// File: rtl/lcc_counter_chk.sv
module lcc_counter_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             clear_n,
   input logic             load,
   input logic [WIDTH-1:0] load_data,
   input logic             count_en,
   input logic             carry_in,
   input logic [WIDTH-1:0] count,
   input logic             carry_out
);

   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] ONES = '1;

   // state is known once a clear or a load has been taken
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clear_n || load) armed <= 1'b1;
   end

   assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!armed)
      !clear_n |=> count == '0);

   assert_clear_beats_load_R2: assert property (@(posedge clk) disable iff (!armed)
      (!clear_n && load) |=> count == '0);

   assert_load_value_R3: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && load) |=> count == $past(load_data));

   assert_increment_R4: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && !load && count_en && carry_in) |=> count == $past(count) + ONE);

   assert_no_cin_hold_R5: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && !load && count_en && !carry_in) |=> $stable(count));

   assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && !load && !count_en) |=> $stable(count));

   assert_carry_out_R7: assert property (@(posedge clk) disable iff (!armed)
      carry_out == (carry_in && count == ONES));

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && !load && count_en && carry_in && count == ONES) |=> count == '0);

endmodule

bind lcc_counter lcc_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .clear_n   (clear_n),
   .load      (load),
   .load_data (load_data),
   .count_en  (count_en),
   .carry_in  (carry_in),
   .count     (count),
   .carry_out (carry_out)
);

// File: tb/lcc_counter_tb.sv
module lcc_counter_tb;
   import lcc_pkg::*;

   localparam int W  = 4;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          clear_n = 1'b1, load = 1'b0, count_en = 1'b0, carry_in = 1'b0;
   logic [W-1:0]  load_data = '0;
   logic [W-1:0]  count;
   logic          carry_out;
   logic [2*CW-1:0] chain_data = '0;
   logic [CW-1:0] lo_count, hi_count;
   logic          lo_cout, hi_cout;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [W-1:0]    exp_q;
   logic [2*CW-1:0] exp_chain;

   always #5 clk = ~clk;

   lcc_counter #(.WIDTH(W), .CARRY_MODE(LCC_CARRY_RIPPLE)) u_dut (
      .clk(clk), .clear_n(clear_n), .load(load), .load_data(load_data),
      .count_en(count_en), .carry_in(carry_in), .count(count), .carry_out(carry_out));

   lcc_counter #(.WIDTH(CW), .CARRY_MODE(LCC_CARRY_PREFIX)) u_chain_lo (
      .clk(clk), .clear_n(clear_n), .load(load), .load_data(chain_data[CW-1:0]),
      .count_en(count_en), .carry_in(1'b1), .count(lo_count), .carry_out(lo_cout));

   lcc_counter #(.WIDTH(CW), .CARRY_MODE(LCC_CARRY_PREFIX)) u_chain_hi (
      .clk(clk), .clear_n(clear_n), .load(load), .load_data(chain_data[2*CW-1:CW]),
      .count_en(count_en), .carry_in(lo_cout), .count(hi_count), .carry_out(hi_cout));

   function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic cn, logic ld,
                                               logic [W-1:0] d, logic en, logic ci);
      if (!cn) return '0;
      if (ld) return d;
      if (en && ci) return cur + W'(1);
      return cur;
   endfunction

   function automatic logic [2*CW-1:0] chain_next(logic [2*CW-1:0] cur, logic cn, logic ld,
                                                  logic [2*CW-1:0] d, logic en);
      if (!cn) return '0;
      if (ld) return d;
      if (en) return cur + (2*CW)'(1);
      return cur;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive at the falling edge, let one rising edge pass, compare at the next falling edge
   task automatic step(logic cn, logic ld, logic [W-1:0] d, logic en, logic ci,
                       logic [2*CW-1:0] cd);
      string tag;
      clear_n = cn; load = ld; load_data = d; count_en = en; carry_in = ci; chain_data = cd;
      if (!cn)            tag = ld ? "R2" : "R1";
      else if (ld)        tag = "R3";
      else if (!en)       tag = "R6";
      else if (!ci)       tag = "R5";
      else if (&exp_q)    tag = "R8";
      else                tag = "R4";
      exp_q     = model_next(exp_q, cn, ld, d, en, ci);
      exp_chain = chain_next(exp_chain, cn, ld, cd, en);
      @(posedge clk);
      @(negedge clk);
      check(tag, int'(count), int'(exp_q));
      check("R7", int'(carry_out), int'(ci && (&exp_q)));
      check("R9", int'({hi_count, lo_count}), int'(exp_chain));
      check("R9", int'(hi_cout), int'(&exp_chain));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      exp_q = '0;
      exp_chain = '0;
      @(negedge clk);
      // R2 / reset state: clear together with load of all ones
      step(1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 6'h3F);
      // R3: load all ones, enable low
      step(1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 6'h3F);
      // R7: carry_in low then high with count all ones and enable off
      step(1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 6'h00);
      step(1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 6'h00);
      // R8: wrap both counters
      step(1'b1, 1'b0, 4'h0, 1'b1, 1'b1, 6'h00);
      // R5: enable high, no carry_in
      step(1'b1, 1'b1, 4'h9, 1'b0, 1'b0, 6'h2A);
      step(1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 6'h00);
      // R1: clear without load
      step(1'b0, 1'b0, 4'h5, 1'b1, 1'b1, 6'h15);
      // R4 run
      for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 4'h0, 1'b1, 1'b1, 6'h00);
      // random mix
      for (int i = 0; i < 600; i++) begin
         logic cn, ld, en, ci;
         cn = ($urandom_range(0, 19) != 0);
         ld = ($urandom_range(0, 9) == 0);
         en = ($urandom_range(0, 3) != 0);
         ci = ($urandom_range(0, 4) != 0);
         step(cn, ld, W'($urandom), en, ci, (2*CW)'($urandom));
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule